// File: doc/BRIEF.md
# Parallel-In Serial-Out Shift Register

This block is a chain of stages, eight by default. It can capture a parallel word in one step and then shift that word out one bit at a time. Everything runs on one system clock. The two shift-clock pins and the mode pin are sampled as ordinary synchronous inputs.

A mode input selects what the chain does. When mode is low, the chain loads the parallel word on every system cycle and ignores both shift-clock pins. When mode is high, the chain shifts one place toward the last stage on each rising edge of the effective shift clock. The serial input then fills the first stage.

The effective shift clock is the OR of two interchangeable pins. Either pin can therefore act as an active-high inhibit for the other. The last stage drives a true output and a separately registered inverted output.

Top module: `plso_shifter`

## Requirements
- R1: While `rst` is high at a clock edge, every stage clears to 0, so after that edge `q_o` is 0 and `q_n_o` is 1.
- R2: With `mode_i` = 0, every stage takes its parallel bit after the clock edge. Bit 0 of `par_i` goes to the first stage and bit STAGES-1 goes to the last stage. So `q_o` first shows `par_i[STAGES-1]`, and each later shift presents the next lower bit.
- R3: While `mode_i` = 0, rising edges on `sclk_a_i` or `sclk_b_i` cause no shift, and the parallel load always wins.
- R4: With `mode_i` = 1, a shift happens on each system clock edge where (`sclk_a_i` | `sclk_b_i`) is 1 and was 0 at the previous edge. On a shift, every stage moves one place toward the last stage and `ser_i` enters the first stage.
- R5: While either shift-clock pin is held at 1, pulses on the other pin cause no shift.
- R6: With no effective rising edge and `mode_i` = 1, the contents and outputs hold indefinitely.
- R7: `q_n_o` is always the logical inverse of `q_o`.
- R8: If the inhibit pin rises while the clock pin is high, and the two pins then fall in either order, the sequence produces exactly one shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | 0 = parallel load, 1 = serial shift |
| sclk_a_i | input | 1 | Shift-clock pin A (interchangeable with B) |
| sclk_b_i | input | 1 | Shift-clock pin B (interchangeable with A) |
| ser_i | input | 1 | Serial data entering the first stage |
| par_i | input | STAGES | Parallel word; bit 0 goes to the first stage |
| q_o | output | 1 | True value of the last stage |
| q_n_o | output | 1 | Inverted value of the last stage |

## Verification
Two functions can fall in the same cycle: the parallel load and a shift-clock edge. The bench provokes this by raising the shift-clock pins while `mode_i` is low, and by driving random per-cycle sequences in which mode, both pins and the data change together. The result is judged at the outputs: after the load the word must appear unshifted, and the remaining bits must follow in the stated order. A second overlap, an inhibit pin rising while the clock pin is high, is judged by counting that exactly one bit moved.

// File: rtl/plso_pkg.sv
package plso_pkg;

    localparam int unsigned DEF_STAGES = 8;

    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } entry_mode_e;

    typedef struct packed {
        logic level;   // merged shift-clock level this cycle
        logic rise;    // merged level rose since last system edge
    } shclk_t;

    function automatic logic merge_pins(input logic a, input logic b);
        return a | b;
    endfunction

endpackage

// File: rtl/plso_clk_merge.sv
module plso_clk_merge
    import plso_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pin_a,
    input  logic   pin_b,
    output shclk_t sclk
);
    logic level_now;
    logic level_prev;

    assign level_now = merge_pins(pin_a, pin_b);

    always_ff @(posedge clk) begin
        if (rst) level_prev <= 1'b0;
        else     level_prev <= level_now;
    end

    always_comb begin
        sclk.level = level_now;
        sclk.rise  = level_now & ~level_prev;
    end

    // R5: a pin held high across two edges blocks any rise
    p_pin_a_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        (pin_a && $past(pin_a)) |-> !sclk.rise);
    p_pin_b_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        (pin_b && $past(pin_b)) |-> !sclk.rise);

endmodule

// File: rtl/plso_stage_chain.sv
module plso_stage_chain
    import plso_pkg::*;
#(
    parameter int unsigned STAGES = DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  entry_mode_e       mode,
    input  logic              advance,
    input  logic              ser,
    input  logic [STAGES-1:0] par,
    output logic              last_q,
    output logic              last_qn
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] cur;
    logic [STAGES-1:0] nxt;
    logic              inv_r;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic feed;
        if (i == 0) begin : g_head
            assign feed = ser;
        end else begin : g_body
            assign feed = cur[i-1];
        end
        always_comb begin
            if (mode == MODE_LOAD) nxt[i] = par[i];
            else if (advance)      nxt[i] = feed;
            else                   nxt[i] = cur[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= '0;
            inv_r <= 1'b1;
        end else begin
            cur   <= nxt;
            inv_r <= ~nxt[LAST];
        end
    end

    assign last_q  = cur[LAST];
    assign last_qn = inv_r;

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LOAD) |=> (cur == $past(par)));
    p_shift_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SHIFT && advance) |=>
        (cur == {$past(cur[LAST-1:0]), $past(ser)}));
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SHIFT && !advance) |=> $stable(cur));
    p_complement_r7: assert property (@(posedge clk) disable iff (rst)
        last_qn == ~last_q);

endmodule

// File: rtl/plso_shifter.sv
module plso_shifter
    import plso_pkg::*;
#(
    parameter int unsigned STAGES = DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_i,
    input  logic              sclk_a_i,
    input  logic              sclk_b_i,
    input  logic              ser_i,
    input  logic [STAGES-1:0] par_i,
    output logic              q_o,
    output logic              q_n_o
);
    shclk_t      sclk;
    entry_mode_e mode;

    assign mode = entry_mode_e'(mode_i);

    plso_clk_merge u_merge (
        .clk   (clk),
        .rst   (rst),
        .pin_a (sclk_a_i),
        .pin_b (sclk_b_i),
        .sclk  (sclk)
    );

    plso_stage_chain #(.STAGES(STAGES)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .advance (sclk.rise),
        .ser     (ser_i),
        .par     (par_i),
        .last_q  (q_o),
        .last_qn (q_n_o)
    );

    // R3: during a load the last stage follows the parallel word, never a shift
    p_load_wins_r3: assert property (@(posedge clk) disable iff (rst)
        (!mode_i && sclk.rise) |=> (q_o == $past(par_i[STAGES-1])));

endmodule

// File: tb/test_plso_shifter.sv
module test_plso_shifter;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_i = 1'b1;
    logic         sclk_a_i = 1'b0;
    logic         sclk_b_i = 1'b0;
    logic         ser_i = 1'b0;
    logic [N-1:0] par_i = '0;
    logic         q_o, q_n_o;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    logic [N-1:0] m = '0;   // model: m[N-1] is the last stage
    logic prev_or = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    plso_shifter #(.STAGES(N)) i_plso_shifter (
        .clk(clk), .rst(rst), .mode_i(mode_i), .sclk_a_i(sclk_a_i),
        .sclk_b_i(sclk_b_i), .ser_i(ser_i), .par_i(par_i),
        .q_o(q_o), .q_n_o(q_n_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            mismatched++;
            $display("FAIL watchdog: run hung, actual=%0d expected<=100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic act, input logic exp, input string req);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_out(input string req);
        chk(q_o, m[N-1], req);
        chk(q_n_o, ~m[N-1], {req, "/R7"});
    endtask

    task automatic do_load(input logic [N-1:0] w);
        mode_i = 1'b0; par_i = w; step();
        m = w;
        mode_i = 1'b1; step();
    endtask

    // one rising edge on pin A, then back low
    task automatic pulse_a(input logic s);
        ser_i = s; sclk_a_i = 1'b1; step();
        m = {m[N-2:0], s};
        sclk_a_i = 1'b0; step();
    endtask

    task automatic t_reset();
        rst = 1'b1; step(); step();
        m = '0;
        chk(q_o, 1'b0, "R1 q after reset");
        chk(q_n_o, 1'b1, "R1 qn after reset");
        rst = 1'b0; step();
        chk_out("R1 hold after release");
    endtask

    task automatic t_load_and_shift(input logic [N-1:0] w, input logic [N-1:0] sbits);
        do_load(w);
        chk_out("R2 first bit after load");
        for (int i = 0; i < N; i++) begin
            pulse_a(sbits[i]);
            chk_out("R4 shift order");
        end
    endtask

    task automatic t_load_priority();
        mode_i = 1'b0; par_i = 8'hA5;
        for (int i = 0; i < 4; i++) begin
            sclk_a_i = 1'b1; sclk_b_i = (i % 2 == 1); step();
            m = 8'hA5;
            chk_out("R3 edge during load");
            sclk_a_i = 1'b0; sclk_b_i = 1'b0; step();
            chk_out("R3 load persists");
        end
        mode_i = 1'b1; step();
        chk_out("R3 after load ends");
        for (int i = 0; i < N; i++) begin
            pulse_a(1'b0);
            chk_out("R3 unshifted word");
        end
    endtask

    task automatic t_inhibit();
        do_load(8'h0F);
        sclk_b_i = 1'b1; ser_i = 1'b1; step();
        m = {m[N-2:0], 1'b1};          // B rising is itself an edge
        chk_out("R5 B edge shifts");
        for (int i = 0; i < 3; i++) begin
            sclk_a_i = 1'b1; step();
            sclk_a_i = 1'b0; step();
            chk_out("R5 A blocked by B");
        end
        sclk_b_i = 1'b0; step();
        chk_out("R5 falling B no shift");
        // R8: clock A rises, inhibit B rises while A high, then both fall
        ser_i = 1'b0; sclk_a_i = 1'b1; step();
        m = {m[N-2:0], 1'b0};
        chk_out("R8 single shift on A");
        sclk_b_i = 1'b1; step();
        chk_out("R8 inhibit rise no shift");
        sclk_a_i = 1'b0; step();
        chk_out("R8 A fall no shift");
        sclk_b_i = 1'b0; step();
        chk_out("R8 B fall no shift");
    endtask

    task automatic t_static();
        do_load(8'h80);
        repeat (200) step();
        chk_out("R6 hold without edges");
        pulse_a(1'b0);
        chk_out("R6 shift after idle");
    endtask

    task automatic t_random();
        prev_or = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            logic nor_now;
            mode_i   = ($urandom_range(0, 9) != 0);
            sclk_a_i = $urandom_range(0, 1);
            sclk_b_i = ($urandom_range(0, 3) == 0);
            ser_i    = $urandom_range(0, 1);
            par_i    = N'($urandom);
            nor_now  = sclk_a_i | sclk_b_i;
            if (!mode_i)                 m = par_i;
            else if (nor_now && !prev_or) m = {m[N-2:0], ser_i};
            prev_or = nor_now;
            step();
            chk_out("R4 random mix");
        end
        mode_i = 1'b1; sclk_a_i = 1'b0; sclk_b_i = 1'b0; step();
    endtask

    initial begin
        t_reset();
        t_load_and_shift(8'b1011_0010, 8'b0110_1101);
        t_load_and_shift(8'hFF, 8'h00);
        t_load_priority();
        t_inhibit();
        t_static();
        t_random();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule